// File: doc/BRIEF.md
# Receive DSCP Priority and Channel Classifier

This block is a per-port receive classifier. Each incoming packet carries a 6-bit DSCP code, flags saying whether it is IPv4 or IPv6, and a fallback priority. The block looks the DSCP code up in a bank of software-programmable map words and produces a 3-bit user priority. If DSCP lookup is not enabled for the packet's IP version, or the packet is not IP at all, the fallback priority is used instead.

The chosen priority is then folded onto one of up to eight receive channels. The fold depends on how many channels are configured. Higher channel numbers carry more urgent traffic, and background traffic (priority 1) ranks below best effort (priority 0). Result fields appear one clock after the packet strobe.

Software reaches the map and the control bits through a simple register port that uses byte addresses. A read returns its data one cycle after the read strobe.

Top module: `dscp_cls_top`

## Requirements
- R1: After reset, the map holds these priorities: DSCP 48 and 56 give 7; DSCP 44 and 46 give 6; DSCP 40 gives 5; the even codes 24 through 38 give 4; DSCP 18, 20 and 22 give 3; DSCP 1 and 8 give 1; every other code gives 0.
- R2: A read of the map word at byte address 0x120+4*w returns the entries for DSCP 8*w+k in bits [4k+3:4k], for k from 0 to 7. The top bit of every 4-bit slot reads as zero. Read data appears on reg_rdata one cycle after reg_rd and holds until the next read.
- R3: A write to a map word stores the low 3 bits of each 4-bit slot and discards the top bit. The stored values are used by subsequent lookups.
- R4: The control word sits at byte address 0x004. Bit 1 enables DSCP lookup for IPv4 packets and bit 2 enables it for IPv6 packets. Both bits are clear after reset, and every other bit reads as zero.
- R5: The DSCP lookup result is used when (pkt_v4 and bit 1) or (pkt_v6 and bit 2) holds. Otherwise out_pri equals pkt_dflt_pri.
- R6: out_valid is pkt_valid delayed by exactly one clock. out_pri and out_chan belong to the packet presented in the previous cycle.
- R7: Priorities 0 to 7 fold onto channels as follows, by configured count:
  - 1: 0,0,0,0,0,0,0,0
  - 2: 0,0,0,0,1,1,1,1
  - 3: 0,0,0,0,1,1,2,2
  - 4: 0,0,1,1,2,2,3,3
  - 5: 0,0,1,1,2,2,3,4
  - 6: 1,0,2,2,3,3,4,5
  - 7: 1,0,2,3,4,4,5,6
  - 8: 1,0,2,3,4,5,6,7
- R8: A channel count of 0 is treated as 1, and a count above 8 is treated as 8. out_chan is always below the effective count.
- R9: A map or control write in the same cycle as a packet does not affect that packet. It takes effect from the next packet on.
- R10: Writes to any address other than the control word or the eight aligned map words change nothing. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| pkt_valid | input | 1 | Packet descriptor strobe |
| pkt_v4 | input | 1 | Packet is IPv4 |
| pkt_v6 | input | 1 | Packet is IPv6 |
| pkt_dscp | input | 6 | DSCP code of the packet |
| pkt_dflt_pri | input | 3 | Fallback priority |
| num_ch | input | 4 | Configured receive channel count (1 to 8) |
| out_valid | output | 1 | Result strobe |
| out_pri | output | 3 | Chosen user priority |
| out_chan | output | 3 | Chosen receive channel |

## Verification
The bench targets the following corner cases:
- **Full reset map and full fold table.** Every one of the 64 reset codes is walked, and every priority is folded under every count from 0 to 15. A wrong table entry, or a count that is not clamped, shows up as a wrong channel, including the swap of priorities 0 and 1.
- **Write of all ones.** A map word written with all ones must read back with its slot top bits cleared. A design that kept bit 3 would return 0xFFFFFFFF and could index past priority 7.
- **Write and packet in the same cycle.** A packet that coincides with a map write must still see the old entry. A design that bypassed the write data into the lookup would report the new priority one packet early.
- **Version enables and stray addresses.** Packets of the wrong IP version or with lookup disabled must fall back to the descriptor priority. Misaligned or out-of-range writes must leave the map and control bits unchanged.

// File: rtl/dscp_cls_pkg.sv
package dscp_cls_pkg;

  localparam int PRI_W = 3;
  localparam int CH_W  = 3;
  localparam int CNT_W = 4;
  localparam int MAX_CH = 8;

  // Power-up DSCP to user priority assignment.
  function automatic logic [2:0] boot_pri(input logic [5:0] code);
    logic [2:0] p;
    case (code)
      6'd48, 6'd56:                                      p = 3'd7;
      6'd44, 6'd46:                                      p = 3'd6;
      6'd40:                                             p = 3'd5;
      6'd24, 6'd26, 6'd28, 6'd30,
      6'd32, 6'd34, 6'd36, 6'd38:                        p = 3'd4;
      6'd18, 6'd20, 6'd22:                               p = 3'd3;
      6'd1, 6'd8:                                        p = 3'd1;
      default:                                           p = 3'd0;
    endcase
    return p;
  endfunction

  // Channel count with out-of-range values pulled into 1..MAX_CH.
  function automatic logic [3:0] clamp_cnt(input logic [3:0] n);
    if (n == 4'd0)                 return 4'd1;
    else if (n > 4'(MAX_CH))       return 4'(MAX_CH);
    else                           return n;
  endfunction

  // Priority to channel fold. Row packs channel for priority p at [3p+2:3p].
  function automatic logic [2:0] fold_chan(input logic [2:0] p, input logic [3:0] n_eff);
    logic [23:0] row;
    case (n_eff)
      4'd2:    row = {3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0};
      4'd3:    row = {3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0};
      4'd4:    row = {3'd3, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0};
      4'd5:    row = {3'd4, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0};
      4'd6:    row = {3'd5, 3'd4, 3'd3, 3'd3, 3'd2, 3'd2, 3'd0, 3'd1};
      4'd7:    row = {3'd6, 3'd5, 3'd4, 3'd4, 3'd3, 3'd2, 3'd0, 3'd1};
      4'd8:    row = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd0, 3'd1};
      default: row = '0;
    endcase
    return row[3*p +: 3];
  endfunction

endpackage

// File: rtl/dscp_map_regs.sv
module dscp_map_regs
  import dscp_cls_pkg::*;
#(
  parameter int DSCP_W   = 6,
  parameter int SLOT_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int MAP_BASE = 'h120,
  parameter int CTL_ADDR = 'h004,
  parameter int V4_BIT   = 1,
  parameter int V6_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DSCP_W-1:0] lk_dscp,
  output logic [PRI_W-1:0]  lk_pri,
  output logic              en_v4,
  output logic              en_v6
);

  localparam int ENTRIES  = 1 << DSCP_W;
  localparam int PER_WORD = DATA_W / SLOT_W;
  localparam int WORDS    = ENTRIES / PER_WORD;
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int BYTES_W  = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(MAP_BASE + WORDS * (DATA_W / 8));
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);

  function automatic logic [DATA_W-1:0] pad_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < PER_WORD; k++)
      m[k*SLOT_W + PRI_W +: SLOT_W - PRI_W] = '1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] PAD_MASK = pad_mask();

  logic [PRI_W-1:0]  slot_q [ENTRIES];
  logic [DATA_W-1:0] word_img [WORDS];
  logic [ADDR_W-1:0] offs;
  logic [WIDX_W-1:0] word_idx;
  logic              map_hit, ctl_hit;
  logic              map_wr, ctl_wr;
  logic              rd_map_q;
  logic [DATA_W-1:0] rdata_q;
  logic              en4_q, en6_q;

  assign offs     = reg_addr - BASE_A;
  assign word_idx = offs[WIDX_W+BYTES_W-1:BYTES_W];
  assign map_hit  = (reg_addr >= BASE_A) && (reg_addr < END_A) &&
                    (reg_addr[BYTES_W-1:0] == '0);
  assign ctl_hit  = (reg_addr == CTL_A);
  assign map_wr   = reg_wr && map_hit;
  assign ctl_wr   = reg_wr && ctl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        slot_q[i] <= boot_pri(6'(i));
    end else if (map_wr) begin
      for (int k = 0; k < PER_WORD; k++)
        slot_q[int'(word_idx) * PER_WORD + k] <= reg_wdata[k*SLOT_W +: PRI_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en4_q <= 1'b0;
      en6_q <= 1'b0;
    end else if (ctl_wr) begin
      en4_q <= reg_wdata[V4_BIT];
      en6_q <= reg_wdata[V6_BIT];
    end
  end

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      word_img[w] = '0;
      for (int k = 0; k < PER_WORD; k++)
        word_img[w][k*SLOT_W +: PRI_W] = slot_q[w*PER_WORD + k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rd_map_q <= 1'b0;
    end else if (reg_rd) begin
      rd_map_q <= map_hit;
      if (map_hit)
        rdata_q <= word_img[word_idx];
      else if (ctl_hit) begin
        rdata_q         <= '0;
        rdata_q[V4_BIT] <= en4_q;
        rdata_q[V6_BIT] <= en6_q;
      end else
        rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign lk_pri    = slot_q[lk_dscp];
  assign en_v4     = en4_q;
  assign en_v6     = en6_q;

  // R2
  map_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_map_q |-> ((reg_rdata & PAD_MASK) == '0));

  // R10
  stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !map_hit && !ctl_hit) |=> (reg_rdata == '0));

endmodule

// File: rtl/dscp_chan_fold.sv
module dscp_chan_fold
  import dscp_cls_pkg::*;
(
  input  logic [PRI_W-1:0] pri,
  input  logic [CNT_W-1:0] num_ch,
  output logic [CNT_W-1:0] cnt_eff,
  output logic [CH_W-1:0]  chan
);

  assign cnt_eff = clamp_cnt(num_ch);
  assign chan    = fold_chan(pri, cnt_eff);

endmodule

// File: rtl/dscp_cls_top.sv
module dscp_cls_top
  import dscp_cls_pkg::*;
#(
  parameter int DSCP_W = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pkt_valid,
  input  logic              pkt_v4,
  input  logic              pkt_v6,
  input  logic [DSCP_W-1:0] pkt_dscp,
  input  logic [PRI_W-1:0]  pkt_dflt_pri,
  input  logic [CNT_W-1:0]  num_ch,
  output logic              out_valid,
  output logic [PRI_W-1:0]  out_pri,
  output logic [CH_W-1:0]   out_chan
);

  logic [PRI_W-1:0] lk_pri;
  logic             en_v4, en_v6;
  logic             use_dscp;
  logic [PRI_W-1:0] sel_pri;
  logic [CNT_W-1:0] cnt_eff;
  logic [CH_W-1:0]  sel_chan;
  logic             valid_q;
  logic [PRI_W-1:0] pri_q;
  logic [CH_W-1:0]  chan_q;

  dscp_map_regs #(
    .DSCP_W (DSCP_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) map_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lk_dscp   (pkt_dscp),
    .lk_pri    (lk_pri),
    .en_v4     (en_v4),
    .en_v6     (en_v6)
  );

  assign use_dscp = (pkt_v4 && en_v4) || (pkt_v6 && en_v6);
  assign sel_pri  = use_dscp ? lk_pri : pkt_dflt_pri;

  dscp_chan_fold fold_i (
    .pri     (sel_pri),
    .num_ch  (num_ch),
    .cnt_eff (cnt_eff),
    .chan    (sel_chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pri_q   <= '0;
      chan_q  <= '0;
    end else begin
      valid_q <= pkt_valid;
      if (pkt_valid) begin
        pri_q  <= sel_pri;
        chan_q <= sel_chan;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_pri   = pri_q;
  assign out_chan  = chan_q;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> out_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !out_valid);

  // R5
  non_ip_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_v4 && !pkt_v6) |=> (out_pri == $past(pkt_dflt_pri)));

  // R8
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> ({1'b0, out_chan} < $past(cnt_eff)));

  // R7
  single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && cnt_eff == 4'd1) |=> (out_chan == '0));

endmodule

// File: tb/dscp_cls_tb.sv
module dscp_cls_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pkt_valid = 1'b0, pkt_v4 = 1'b0, pkt_v6 = 1'b0;
  logic [5:0]  pkt_dscp = '0;
  logic [2:0]  pkt_dflt_pri = '0;
  logic [3:0]  num_ch = 4'd8;
  logic        out_valid;
  logic [2:0]  out_pri, out_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int     mdl_map [64];
  bit     mdl_en4, mdl_en6;

  int fold_tab [8][8] = '{
    '{0,0,0,0,0,0,0,0},
    '{0,0,0,0,1,1,1,1},
    '{0,0,0,0,1,1,2,2},
    '{0,0,1,1,2,2,3,3},
    '{0,0,1,1,2,2,3,4},
    '{1,0,2,2,3,3,4,5},
    '{1,0,2,3,4,4,5,6},
    '{1,0,2,3,4,5,6,7}};

  always #10 clk = ~clk;

  dscp_cls_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_valid(pkt_valid), .pkt_v4(pkt_v4), .pkt_v6(pkt_v6),
    .pkt_dscp(pkt_dscp), .pkt_dflt_pri(pkt_dflt_pri), .num_ch(num_ch),
    .out_valid(out_valid), .out_pri(out_pri), .out_chan(out_chan));

  function automatic int ref_boot(int d);
    if (d inside {48, 56}) return 7;
    if (d inside {44, 46}) return 6;
    if (d == 40) return 5;
    if (d >= 24 && d <= 38 && (d % 2) == 0) return 4;
    if (d inside {18, 20, 22}) return 3;
    if (d inside {1, 8}) return 1;
    return 0;
  endfunction

  function automatic int ref_chan(int p, int n);
    int c;
    c = (n < 1) ? 1 : (n > 8) ? 8 : n;
    return fold_tab[c-1][p];
  endfunction

  function automatic int ref_pri(bit v4, bit v6, int d, int dp);
    if ((v4 && mdl_en4) || (v6 && mdl_en6)) return mdl_map[d];
    return dp;
  endfunction

  function automatic logic [31:0] ref_word(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) r[4*k +: 4] = 4'(mdl_map[8*w + k]);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; pkt_valid = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 12'h004) begin mdl_en4 = d[1]; mdl_en6 = d[2]; end
    else if (a >= 12'h120 && a < 12'h140 && a[1:0] == 2'b00)
      for (int k = 0; k < 8; k++) mdl_map[(a - 12'h120) / 4 * 8 + k] = int'(d[4*k +: 3]);
    tick();
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pkt_chk(string tag, bit v4, bit v6, int d, int dp, int n);
    int ep;
    ep = ref_pri(v4, v6, d, dp);
    pkt_valid = 1'b1; pkt_v4 = v4; pkt_v6 = v6;
    pkt_dscp = 6'(d); pkt_dflt_pri = 3'(dp); num_ch = 4'(n);
    tick();
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " pri"}, 32'(out_pri), 32'(ep));
    chk({tag, " chan"}, 32'(out_chan), 32'(ref_chan(ep, n)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mdl_map[i] = ref_boot(i);
    mdl_en4 = 0; mdl_en6 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R6 reset out_valid", 32'(out_valid), 32'd0);
    rd_chk("R4 reset ctl", 12'h004, 32'd0);
    for (int w = 0; w < 8; w++) rd_chk("R1 R2 reset map word", 12'(12'h120 + 4*w), ref_word(w));

    // R5: lookup disabled, fallback used
    pkt_chk("R5 v4 disabled", 1, 0, 56, 2, 8);
    pkt_chk("R5 v6 disabled", 0, 1, 46, 3, 8);

    // R4: only enable bits kept
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R4 ctl all ones", 12'h004, 32'h0000_0006);
    wr(12'h004, 32'h0000_0002);
    rd_chk("R4 ctl v4 only", 12'h004, 32'h0000_0002);
    pkt_chk("R5 v6 with v4-only enable", 0, 1, 48, 5, 8);
    pkt_chk("R5 non-ip", 0, 0, 48, 6, 8);

    // R1 R7: walk every code through v4 lookup at 8 channels
    for (int d = 0; d < 64; d++) pkt_chk("R1 R7 walk", 1, 0, d, 0, 8);

    // R7 R8: every priority under every count via fallback
    for (int n = 0; n < 16; n++)
      for (int p = 0; p < 8; p++) pkt_chk("R7 R8 fold", 0, 0, 0, p, n);

    // R3: slot top bit discarded
    wr(12'h004, 32'h0000_0004);
    wr(12'h128, 32'hFFFF_FFFF);
    rd_chk("R3 all ones word", 12'h128, 32'h7777_7777);
    pkt_chk("R3 v6 lookup after write", 0, 1, 8, 0, 8);
    wr(12'h128, 32'h8765_4321);
    rd_chk("R3 mixed word", 12'h128, 32'h0765_4321);
    pkt_chk("R3 lookup slot 7", 0, 1, 15, 0, 4);

    // R9: write in same cycle as packet
    begin
      int old_p;
      old_p = mdl_map[40];
      pkt_valid = 1'b1; pkt_v4 = 1'b0; pkt_v6 = 1'b1; pkt_dscp = 6'd40;
      pkt_dflt_pri = 3'd0; num_ch = 4'd8;
      reg_wr = 1'b1; reg_addr = 12'h134; reg_wdata = 32'h0000_0002;
      for (int k = 0; k < 8; k++) mdl_map[40 + k] = int'(reg_wdata[4*k +: 3]);
      tick();
      chk("R9 same-cycle packet old pri", 32'(out_pri), 32'(old_p));
      pkt_chk("R9 next packet new pri", 0, 1, 40, 0, 8);
    end

    // R10: stray addresses
    wr(12'h140, 32'hFFFF_FFFF);
    wr(12'h122, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h11C, 32'hFFFF_FFFF);
    rd_chk("R10 ctl unchanged", 12'h004, 32'h0000_0004);
    for (int w = 0; w < 8; w++) rd_chk("R10 map unchanged", 12'(12'h120 + 4*w), ref_word(w));
    rd_chk("R10 stray read", 12'h140, 32'd0);
    rd_chk("R10 misaligned read", 12'h121, 32'd0);

    // R6: idle cycle drops valid
    tick();
    chk("R6 idle out_valid", 32'(out_valid), 32'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) wr(12'h004, $urandom);
      else if (op == 1) wr(12'(12'h120 + 4 * $urandom_range(0, 7)), $urandom);
      else if (op == 2) begin
        int w;
        w = int'($urandom_range(0, 7));
        rd_chk("R2 random read", 12'(12'h120 + 4*w), ref_word(w));
      end else
        pkt_chk("R5 R7 random", 1'($urandom), 1'($urandom), int'($urandom_range(0, 63)),
                int'($urandom_range(0, 7)), int'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule